// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block sits between an interrupt distributor and a set of CPU interfaces. For every CPU it scans the implemented interrupt IDs and looks for those that are both enabled and pending for that CPU. It picks the one with the smallest priority value and presents its ID to that CPU. If that priority is below both the CPU's priority mask and its running priority, it also raises the CPU's interrupt request line.

The block keeps a per-CPU set of active interrupts. An acknowledge does four things: it returns the current pending ID, marks that interrupt active, issues a one-cycle clear of its pending bit back to the distributor, and so makes its priority the running priority. An end-of-interrupt retires an active interrupt. The running priority then falls back to the best priority still active. An end-of-interrupt that names an ID outside the implemented range is dropped, and this includes the spurious ID 1023. The interrupt count is a parameter, and ID 1023 means "nothing pending".

Top module: `hp_irq_select`

## Requirements
- R1: After reset every CPU shows pending ID 1023, a low request line, running priority 0x100 and running ID 1023. Its priority mask is 0xF0, so an interrupt of priority 0xF0 is presented but raises no request.
- R2: An interrupt is a candidate for a CPU only when its bit in `enable_i` and its bit for that CPU in `pending_i` are both set. Only IDs 0 to NUM_IRQ-1 exist.
- R3: Among the candidates, the smallest 8-bit priority value wins. On equal priority the lower ID wins.
- R4: With no candidate, the pending ID is 1023 and the request is low. When `dist_en_i` or that CPU's `cpu_en_i` bit is low, the pending ID is also 1023 and the request is also low.
- R5: The request line is high only when the winning priority is strictly below both the mask and the running priority. A pending interrupt that does not preempt the running one raises no request.
- R6: An acknowledge while a valid ID is presented does four things. It returns that ID on `ack_id_o` in the same cycle and pulses only that ID's bit of `pend_clr_o`. It marks the ID active, and from the next cycle the ID's priority shows as the running priority and the ID as the running ID.
- R7: An acknowledge while the pending ID is 1023 returns 1023. It clears no pending bit and changes no running state.
- R8: An end-of-interrupt naming an ID below NUM_IRQ makes that ID inactive. The running priority and running ID then become those of the best remaining active interrupt (smallest priority, then lowest ID), or 0x100 and 1023 when none remains.
- R9: An end-of-interrupt naming an ID at or above NUM_IRQ, including 1023, changes no running state.
- R10: The pending ID and the request line are registered. They reflect the inputs sampled at the previous clock edge.
- R11: A mask write for one CPU loads `mask_wdata_i` as that CPU's mask and leaves the other CPUs' masks unchanged.
- R12: Each CPU is selected independently from its own pending vector, mask and active set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dist_en_i | input | 1 | Distributor enable |
| cpu_en_i | input | NUM_CPU | Per-CPU interface enable |
| enable_i | input | NUM_IRQ | Per-interrupt enable |
| pending_i | input | NUM_CPU*NUM_IRQ | Pending bits, CPU c at slice c*NUM_IRQ |
| prio_i | input | NUM_IRQ*8 | Priority of interrupt i at bits i*8 +: 8 |
| mask_we_i | input | NUM_CPU | Per-CPU mask write strobe |
| mask_wdata_i | input | 8 | Mask write value |
| ack_i | input | NUM_CPU | Per-CPU acknowledge strobe |
| eoi_i | input | NUM_CPU | Per-CPU end-of-interrupt strobe |
| eoi_id_i | input | 10 | ID carried by the end-of-interrupt |
| irq_o | output | NUM_CPU | Per-CPU interrupt request |
| pend_id_o | output | NUM_CPU*10 | Per-CPU current pending ID |
| ack_id_o | output | NUM_CPU*10 | ID returned by an acknowledge (1023 when idle) |
| pend_clr_o | output | NUM_CPU*NUM_IRQ | One-cycle pending clear toward the distributor |
| run_prio_o | output | NUM_CPU*9 | Per-CPU running priority, 0x100 when idle |
| run_id_o | output | NUM_CPU*10 | Per-CPU running ID, 1023 when idle |

## Verification
A corrupted active set shows on `run_prio_o` and `run_id_o` in the cycle after the faulty update. One cycle later it also shows on the request line, as a missed or a false preemption. A bad winner choice or a stale mask shows on `pend_id_o` or `irq_o` one edge after the inputs settle. A wrong acknowledge target shows at once on `ack_id_o` and `pend_clr_o`. The bench holds each stimulus for two cycles, so every registered path has settled before sampling. It also checks the acknowledge outputs inside the strobe cycle itself.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = PRIO_W + 1;

  typedef logic [ID_W-1:0]   irq_id_t;
  typedef logic [RUN_W-1:0]  run_prio_t;
  typedef logic [PRIO_W-1:0] prio_t;

  localparam irq_id_t   SPURIOUS_ID = irq_id_t'(1023);
  localparam run_prio_t IDLE_PRIO   = run_prio_t'(9'h100);
  localparam prio_t     MASK_RST    = prio_t'(8'hF0);
endpackage

// File: rtl/hp_irq_min_find.sv
module hp_irq_min_find
  import hp_irq_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output run_prio_t           best_prio_o,
  output irq_id_t             best_id_o
);
  // strict compare keeps the lower ID on ties
  always_comb begin
    best_prio_o = IDLE_PRIO;
    best_id_o   = SPURIOUS_ID;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < best_prio_o)) begin
        best_prio_o = {1'b0, prio_i[i*PRIO_W +: PRIO_W]};
        best_id_o   = irq_id_t'(i);
      end
    end
  end
endmodule

// File: rtl/hp_irq_cpu_slot.sv
module hp_irq_cpu_slot
  import hp_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [NUM_IRQ-1:0]        enable_i,
  input  logic [NUM_IRQ-1:0]        pending_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic                      mask_we_i,
  input  prio_t                     mask_wdata_i,
  input  logic                      ack_i,
  input  logic                      eoi_i,
  input  irq_id_t                   eoi_id_i,
  output logic                      irq_o,
  output irq_id_t                   pend_id_o,
  output irq_id_t                   ack_id_o,
  output logic [NUM_IRQ-1:0]        pend_clr_o,
  output run_prio_t                 run_prio_o,
  output irq_id_t                   run_id_o
);
  prio_t              mask_q;
  logic [NUM_IRQ-1:0] active_q, active_d;
  irq_id_t            pend_id_q;
  logic               irq_q;
  run_prio_t          cand_prio, run_prio;
  irq_id_t            cand_id, run_id;
  logic               ack_hit;

  hp_irq_min_find #(.N(NUM_IRQ)) u_cand (
    .valid_i     (enable_i & pending_i),
    .prio_i      (prio_i),
    .best_prio_o (cand_prio),
    .best_id_o   (cand_id)
  );

  hp_irq_min_find #(.N(NUM_IRQ)) u_run (
    .valid_i     (active_q),
    .prio_i      (prio_i),
    .best_prio_o (run_prio),
    .best_id_o   (run_id)
  );

  assign ack_hit = ack_i && (pend_id_q != SPURIOUS_ID);

  // EOI outside 0..NUM_IRQ-1 matches no bit and is dropped
  always_comb begin
    active_d   = active_q;
    pend_clr_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eoi_i && (eoi_id_i == irq_id_t'(i))) active_d[i] = 1'b0;
      if (ack_hit && (pend_id_q == irq_id_t'(i))) begin
        active_d[i]   = 1'b1;
        pend_clr_o[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= MASK_RST;
      active_q  <= '0;
      pend_id_q <= SPURIOUS_ID;
      irq_q     <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      active_q  <= active_d;
      pend_id_q <= en_i ? cand_id : SPURIOUS_ID;
      irq_q     <= en_i && (cand_prio < {1'b0, mask_q}) && (cand_prio < run_prio);
    end
  end

  assign irq_o      = irq_q;
  assign pend_id_o  = pend_id_q;
  assign ack_id_o   = ack_i ? pend_id_q : SPURIOUS_ID;
  assign run_prio_o = run_prio;
  assign run_id_o   = run_id;
endmodule

// File: rtl/hp_irq_select.sv
module hp_irq_select
  import hp_irq_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dist_en_i,
  input  logic [NUM_CPU-1:0]        cpu_en_i,
  input  logic [NUM_IRQ-1:0]        enable_i,
  input  logic [NUM_CPU*NUM_IRQ-1:0] pending_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [NUM_CPU-1:0]        mask_we_i,
  input  logic [PRIO_W-1:0]         mask_wdata_i,
  input  logic [NUM_CPU-1:0]        ack_i,
  input  logic [NUM_CPU-1:0]        eoi_i,
  input  logic [ID_W-1:0]           eoi_id_i,
  output logic [NUM_CPU-1:0]        irq_o,
  output logic [NUM_CPU*ID_W-1:0]   pend_id_o,
  output logic [NUM_CPU*ID_W-1:0]   ack_id_o,
  output logic [NUM_CPU*NUM_IRQ-1:0] pend_clr_o,
  output logic [NUM_CPU*RUN_W-1:0]  run_prio_o,
  output logic [NUM_CPU*ID_W-1:0]   run_id_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    hp_irq_cpu_slot #(.NUM_IRQ(NUM_IRQ)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (dist_en_i & cpu_en_i[c]),
      .enable_i     (enable_i),
      .pending_i    (pending_i[c*NUM_IRQ +: NUM_IRQ]),
      .prio_i       (prio_i),
      .mask_we_i    (mask_we_i[c]),
      .mask_wdata_i (mask_wdata_i),
      .ack_i        (ack_i[c]),
      .eoi_i        (eoi_i[c]),
      .eoi_id_i     (eoi_id_i),
      .irq_o        (irq_o[c]),
      .pend_id_o    (pend_id_o[c*ID_W +: ID_W]),
      .ack_id_o     (ack_id_o[c*ID_W +: ID_W]),
      .pend_clr_o   (pend_clr_o[c*NUM_IRQ +: NUM_IRQ]),
      .run_prio_o   (run_prio_o[c*RUN_W +: RUN_W]),
      .run_id_o     (run_id_o[c*ID_W +: ID_W])
    );
  end
endmodule

// File: rtl/hp_irq_select_chk.sv
module hp_irq_select_chk
  import hp_irq_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_CPU-1:0]         ack_i,
  input logic [NUM_CPU-1:0]         eoi_i,
  input logic [ID_W-1:0]            eoi_id_i,
  input logic [NUM_CPU-1:0]         irq_o,
  input logic [NUM_CPU*ID_W-1:0]    pend_id_o,
  input logic [NUM_CPU*NUM_IRQ-1:0] pend_clr_o,
  input logic [NUM_CPU*RUN_W-1:0]   run_prio_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_irq_has_id_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (pend_id_o[c*ID_W +: ID_W] != SPURIOUS_ID));

    assert_id_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_id_o[c*ID_W +: ID_W] == SPURIOUS_ID) ||
      (pend_id_o[c*ID_W +: ID_W] < irq_id_t'(NUM_IRQ)));

    assert_clr_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(pend_clr_o[c*NUM_IRQ +: NUM_IRQ]));

    assert_ack_sets_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[c] && !eoi_i[c] && (pend_id_o[c*ID_W +: ID_W] != SPURIOUS_ID))
      |=> (run_prio_o[c*RUN_W +: RUN_W] != IDLE_PRIO));

    assert_spurious_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[c] && (pend_id_o[c*ID_W +: ID_W] == SPURIOUS_ID))
      |-> (pend_clr_o[c*NUM_IRQ +: NUM_IRQ] == '0));

    assert_eoi_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_i[c] && !ack_i[c] && (eoi_id_i >= irq_id_t'(NUM_IRQ)))
      |=> $stable(run_prio_o[c*RUN_W +: RUN_W]));
  end
endmodule

bind hp_irq_select hp_irq_select_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .eoi_i      (eoi_i),
  .eoi_id_i   (eoi_id_i),
  .irq_o      (irq_o),
  .pend_id_o  (pend_id_o),
  .pend_clr_o (pend_clr_o),
  .run_prio_o (run_prio_o)
);

// File: tb/hp_irq_select_tb_top.sv
`timescale 1ns/1ps
module hp_irq_select_tb_top;
  localparam int NC = 2;
  localparam int NI = 64;
  localparam int IW = 10;
  localparam int RW = 9;
  localparam int VW = 64 + 64 + IW + 1;
  localparam int NVEC = 8;

  // {pending cpu0, enable, expected id, expected irq}; priority of i is {i[2:0],5'b0}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {64'h0000_0000_0000_0020, 64'hFFFF_FFFF_FFFF_FFFF, 10'd5,    1'b1},
    {64'h0000_0000_0000_0048, 64'hFFFF_FFFF_FFFF_FFFF, 10'd3,    1'b1},
    {64'h0000_0000_0002_0200, 64'hFFFF_FFFF_FFFF_FFFF, 10'd9,    1'b1},
    {64'h8000_0000_0000_0080, 64'hFFFF_FFFF_FFFF_FFFF, 10'd7,    1'b1},
    {64'h0000_0000_0000_5000, 64'hFFFF_FFFF_FFFF_EFFF, 10'd14,   1'b1},
    {64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 10'd0,    1'b1},
    {64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 10'd1023, 1'b0},
    {64'h0000_0100_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF, 10'd40,   1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dist_en = 1'b1;
  logic [NC-1:0] cpu_en = '1;
  logic [NI-1:0] enable = '1;
  logic [NC*NI-1:0] pend = '0;
  logic [7:0] prio_tb [NI];
  logic [NI*8-1:0] prio_bus;
  logic [NC-1:0] mask_we = '0;
  logic [7:0] mask_wdata = '0;
  logic [NC-1:0] ack = '0;
  logic [NC-1:0] eoi = '0;
  logic [IW-1:0] eoi_id = '0;
  logic [NC-1:0] irq;
  logic [NC*IW-1:0] pend_id, ack_id, run_id;
  logic [NC*NI-1:0] pend_clr;
  logic [NC*RW-1:0] run_prio;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < NI; i++) prio_bus[i*8 +: 8] = prio_tb[i];

  hp_irq_select #(.NUM_CPU(NC), .NUM_IRQ(NI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
    .enable_i(enable), .pending_i(pend), .prio_i(prio_bus),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .ack_i(ack), .eoi_i(eoi),
    .eoi_id_i(eoi_id), .irq_o(irq), .pend_id_o(pend_id), .ack_id_o(ack_id),
    .pend_clr_o(pend_clr), .run_prio_o(run_prio), .run_id_o(run_id)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [IW-1:0] pid(input int c); return pend_id[c*IW +: IW]; endfunction
  function automatic logic [RW-1:0] rpr(input int c); return run_prio[c*RW +: RW]; endfunction
  function automatic logic [IW-1:0] rid(input int c); return run_id[c*IW +: IW]; endfunction

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NI; i++) prio_tb[i] = {i[2:0], 5'b0};
    step(3);
    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      chk("R1 pend_id", pid(c), 1023);
      chk("R1 irq", irq[c], 0);
      chk("R1 run_prio", rpr(c), 9'h100);
      chk("R1 run_id", rid(c), 1023);
    end
    rst_n = 1'b1;
    step(2);

    // R2 R3 R4 vector walk on CPU 0
    for (int v = 0; v < NVEC; v++) begin
      pend[0 +: NI] = VEC[v][VW-1 -: 64];
      enable        = VEC[v][VW-65 -: 64];
      step(2);
      chk("R3 R2 vector pend_id", pid(0), VEC[v][IW:1]);
      chk("R5 R4 vector irq", irq[0], VEC[v][0]);
    end
    enable = '1;

    // R1 reset mask is 0xF0: priority 0xF0 presented, no request
    prio_tb[7] = 8'hF0;
    pend = '0; pend[7] = 1'b1;
    step(2);
    chk("R1 mask id", pid(0), 7);
    chk("R1 mask irq", irq[0], 0);
    prio_tb[7] = 8'hE0;

    // R4 disables
    pend = '0; pend[5] = 1'b1;
    cpu_en[0] = 1'b0;
    step(2);
    chk("R4 cpu_en id", pid(0), 1023);
    chk("R4 cpu_en irq", irq[0], 0);
    cpu_en[0] = 1'b1; dist_en = 1'b0;
    step(2);
    chk("R4 dist_en id", pid(0), 1023);
    chk("R4 dist_en irq", irq[0], 0);
    dist_en = 1'b1;
    step(2);
    chk("R4 re-enable id", pid(0), 5);

    // R12 independent CPUs
    pend[NI + 2] = 1'b1;
    step(2);
    chk("R12 cpu0 id", pid(0), 5);
    chk("R12 cpu1 id", pid(1), 2);
    chk("R12 cpu1 irq", irq[1], 1);
    pend[NI +: NI] = '0;

    // R6 acknowledge
    pend[3] = 1'b1;
    step(2);
    chk("R6 pre id", pid(0), 3);
    ack[0] = 1'b1; pend[3] = 1'b0;
    #1;
    chk("R6 ack_id", ack_id[0 +: IW], 3);
    chk("R6 pend_clr", pend_clr[0 +: NI], 64'h8);
    @(negedge clk); ack[0] = 1'b0;
    step(1);
    chk("R6 run_prio", rpr(0), 9'h060);
    chk("R6 run_id", rid(0), 3);
    chk("R5 no preempt id", pid(0), 5);
    chk("R5 no preempt irq", irq[0], 0);

    // R5 preemption by a better priority
    pend[1] = 1'b1;
    step(2);
    chk("R5 preempt id", pid(0), 1);
    chk("R5 preempt irq", irq[0], 1);
    ack[0] = 1'b1; pend[1] = 1'b0;
    #1;
    chk("R6 nested ack_id", ack_id[0 +: IW], 1);
    @(negedge clk); ack[0] = 1'b0;
    step(1);
    chk("R6 nested run_prio", rpr(0), 9'h020);
    chk("R6 nested run_id", rid(0), 1);
    chk("R5 nested irq", irq[0], 0);

    // R9 out-of-range EOIs ignored
    eoi[0] = 1'b1; eoi_id = 10'd1023;
    @(negedge clk); eoi_id = 10'd64;
    @(negedge clk); eoi[0] = 1'b0;
    step(1);
    chk("R9 run_prio", rpr(0), 9'h020);
    chk("R9 run_id", rid(0), 1);

    // R8 EOI unwinds to the remaining active interrupt
    eoi[0] = 1'b1; eoi_id = 10'd1;
    @(negedge clk); eoi[0] = 1'b0;
    step(1);
    chk("R8 run_prio", rpr(0), 9'h060);
    chk("R8 run_id", rid(0), 3);
    chk("R8 irq", irq[0], 0);
    eoi[0] = 1'b1; eoi_id = 10'd3;
    @(negedge clk); eoi[0] = 1'b0;
    step(1);
    chk("R8 idle prio", rpr(0), 9'h100);
    chk("R8 idle id", rid(0), 1023);
    chk("R8 irq back", irq[0], 1);

    // R7 spurious acknowledge
    pend = '0;
    step(2);
    ack[0] = 1'b1;
    #1;
    chk("R7 ack_id", ack_id[0 +: IW], 1023);
    chk("R7 pend_clr", pend_clr[0 +: NI], 0);
    @(negedge clk); ack[0] = 1'b0;
    step(1);
    chk("R7 run_prio", rpr(0), 9'h100);
    chk("R7 run_id", rid(0), 1023);

    // R10 one-edge latency
    pend[2] = 1'b1;
    #1;
    chk("R10 before edge", pid(0), 1023);
    @(negedge clk);
    chk("R10 after edge", pid(0), 2);
    pend = '0;

    // R11 per-CPU mask write
    mask_we[0] = 1'b1; mask_wdata = 8'hA0;
    @(negedge clk); mask_we = '0;
    pend[5] = 1'b1; pend[NI + 5] = 1'b1;
    step(2);
    chk("R11 masked id", pid(0), 5);
    chk("R11 masked irq", irq[0], 0);
    chk("R11 other cpu irq", irq[1], 1);
    pend[4] = 1'b1;
    step(2);
    chk("R11 below mask id", pid(0), 4);
    chk("R11 below mask irq", irq[0], 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule